// File: doc/BRIEF.md
# Frame-Synchronous GPIO Port Controller

This block runs four general-purpose pins next to a serial converter link that is framed by an active-low chip select. The deserialised input word of each frame goes to the block as one parallel word. Program words set each pin to input or output and can give pin 0 an alarm-output role or pin 3 a power-down-input role. Run words carry the output levels and a header select for the next frame. All of these take effect in step with the chip-select falling edge that opens the following frame. Pin levels are also captured at that edge, so the 16-bit reply word can carry them in its top nibble instead of the channel tag.

The block samples chip select in the system clock domain and finds its falling edge there. At that edge it moves the pending output levels onto the pins, moves the pending header select into use, and takes a snapshot of the pin state. The power-down request does not wait for a frame: the request output follows the pin directly, and a separate status flag gives a synchronised copy of it. A build parameter selects a reduced-pin variant in which only pin 0 is usable. That variant accepts only configurations that keep pins 1 to 3 as outputs.

Top module: `gpio_fs_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), the held output levels are 0, the header carries `chan_tag`, and `pd_flag` is 0.
- R2: A program word (bits 15..12 = 4'h4) with legal content writes its bits 3..0 as pin directions (bit i = 1 makes pin i an output), and `pin_oe` shows them on the next clock.
- R3: A run word (bits 15..12 = 4'h1) stores bits 3..0 as pending output levels. `pin_out` keeps its old value until the next chip-select falling edge and shows the new levels from that edge on.
- R4: At each chip-select falling edge an input pin's level is captured. Later pin changes within the frame do not alter the captured value seen in `sdo_word`.
- R5: Bit 4 of a run word selects the header for the frames that start after it. With 1, `sdo_word[15:12]` is the captured state of pins 3..0 (pin 3 in bit 15). With 0 it is `chan_tag`. `sdo_word[11:0]` always equals `result`.
- R6: Program-word bit 8 assigns the alarm role to pin 0. Pin 0 is then driven (`pin_oe[0]` = 1) with `alarm_hi | alarm_lo`, and its captured state is the alarm level.
- R7: Program-word bit 9 assigns the power-down role to pin 3. Pin 3 is then undriven, and `pd_active` equals the inverse of `pin_in[3]` with no clock delay. `pd_flag` follows `pd_active` two clocks later.
- R8: With `NARROW` = 1, a program word whose bits 3..1 are not all 1, or whose bit 9 is set, is rejected and leaves the configuration unchanged.
- R9: Words whose bits 15..12 are neither 4'h1 nor 4'h4 are ignored. So are program words with any of bits 11..10 or 7..4 set. Neither changes the pins or the pending state.
- R10: For a pin that is an output, the captured state is the level driven from that same chip-select falling edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame chip select, active low, sampled on `clk` |
| word_valid | input | 1 | One-cycle strobe: `word_in` holds a complete frame word |
| word_in | input | 16 | Deserialised input word of the current frame |
| chan_tag | input | 4 | Channel tag for the reply header |
| result | input | 12 | Conversion result for the reply's lower bits |
| alarm_hi | input | 1 | High-threshold alarm flag |
| alarm_lo | input | 1 | Low-threshold alarm flag |
| pin_in | input | 4 | Sensed pad levels |
| pin_out | output | 4 | Pad output levels |
| pin_oe | output | 4 | Pad output enables, 1 = driven |
| sdo_word | output | 16 | Reply word for the current frame |
| pd_active | output | 1 | Unclocked power-down request from pin 3 |
| pd_flag | output | 1 | Synchronised power-down status |

## Verification
The assertions assume that `cs_n`, `word_valid` and `word_in` are synchronous to `clk`. They also assume that `word_valid` is a single-cycle strobe, so one word never counts twice. The stimulus changes every input just after a falling clock edge and holds chip select high for at least two clocks between frames, so each falling edge is seen exactly once. The pads are modelled as plain inputs in `pin_in`, with no contention against `pin_out`, so the captured state depends only on what the stimulus drives.

// File: rtl/gpio_fs_pkg.sv
package gpio_fs_pkg;

    localparam int NPINS    = 4;
    localparam int WORD_W   = 16;
    localparam int OP_W     = 4;
    localparam int RES_W    = WORD_W - NPINS;
    localparam int ALM_PIN  = 0;
    localparam int PD_PIN   = NPINS - 1;

    localparam logic [OP_W-1:0] OP_RUN    = 4'h1;
    localparam logic [OP_W-1:0] OP_PINCFG = 4'h4;

    localparam int HDR_BIT  = 4;
    localparam int ALM_BIT  = 8;
    localparam int PD_BIT   = 9;

    typedef struct packed {
        logic             pd_en;
        logic             alarm_en;
        logic [NPINS-1:0] dir;
    } pin_cfg_t;

    typedef struct packed {
        logic             hdr_sel;
        logic [NPINS-1:0] data;
    } run_t;

    function automatic logic [OP_W-1:0] word_op(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: OP_W];
    endfunction

    function automatic pin_cfg_t decode_cfg(input logic [WORD_W-1:0] w);
        pin_cfg_t c;
        c.pd_en    = w[PD_BIT];
        c.alarm_en = w[ALM_BIT];
        c.dir      = w[NPINS-1:0];
        return c;
    endfunction

    function automatic run_t decode_run(input logic [WORD_W-1:0] w);
        run_t r;
        r.hdr_sel = w[HDR_BIT];
        r.data    = w[NPINS-1:0];
        return r;
    endfunction

    function automatic logic cfg_legal(input logic [WORD_W-1:0] w, input logic narrow);
        logic rsv_clear;
        logic narrow_ok;
        rsv_clear = (w[11:10] == 2'b00) && (w[7:4] == 4'b0000);
        narrow_ok = (w[NPINS-1:1] == '1) && !w[PD_BIT];
        return rsv_clear && (!narrow || narrow_ok);
    endfunction

endpackage

// File: rtl/gpio_fs_edge.sv
module gpio_fs_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic pd_req,
    output logic cs_fall,
    output logic pd_flag
);
    logic                   cs_q;
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sync_q <= '0;
        end else begin
            cs_q   <= cs_n;
            sync_q <= {sync_q[SYNC_STAGES-2:0], pd_req};
        end
    end

    assign cs_fall = cs_q & ~cs_n;
    assign pd_flag = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_fs_cfg.sv
module gpio_fs_cfg
    import gpio_fs_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              cs_fall,
    output pin_cfg_t          cfg_q,
    output logic [NPINS-1:0]  drive_q,
    output logic [NPINS-1:0]  drive_next,
    output logic              hdr_act
);
    run_t pend_q;
    logic take_cfg;
    logic take_run;

    assign take_cfg = word_valid && (word_op(word_in) == OP_PINCFG) && cfg_legal(word_in, NARROW);
    assign take_run = word_valid && (word_op(word_in) == OP_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            pend_q <= '0;
        end else begin
            if (take_cfg) cfg_q  <= decode_cfg(word_in);
            if (take_run) pend_q <= decode_run(word_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= '0;
            hdr_act <= 1'b0;
        end else if (cs_fall) begin
            drive_q <= pend_q.data;
            hdr_act <= pend_q.hdr_sel;
        end
    end

    assign drive_next = pend_q.data;
endmodule

// File: rtl/gpio_fs_pin.sv
module gpio_fs_pin #(
    parameter bit HAS_ALARM = 1'b0,
    parameter bit HAS_PD    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_fall,
    input  logic dir,
    input  logic func_en,
    input  logic alarm_any,
    input  logic drive_q,
    input  logic drive_next,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic snap
);
    logic alarm_sel;
    logic pd_sel;
    logic gpo_sel;

    assign alarm_sel = HAS_ALARM & func_en;
    assign pd_sel    = HAS_PD & func_en;
    assign gpo_sel   = dir & ~pd_sel & ~alarm_sel;

    assign pad_oe  = alarm_sel | gpo_sel;
    assign pad_out = alarm_sel ? alarm_any : drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= 1'b0;
        end else if (cs_fall) begin
            if (alarm_sel)    snap <= alarm_any;
            else if (gpo_sel) snap <= drive_next;
            else              snap <= pad_in;
        end
    end
endmodule

// File: rtl/gpio_fs_ctrl.sv
module gpio_fs_ctrl
    import gpio_fs_pkg::*;
#(
    parameter bit NARROW      = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic [NPINS-1:0]  chan_tag,
    input  logic [RES_W-1:0]  result,
    input  logic              alarm_hi,
    input  logic              alarm_lo,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [WORD_W-1:0] sdo_word,
    output logic              pd_active,
    output logic              pd_flag
);
    logic             cs_fall;
    pin_cfg_t         cfg_q;
    logic [NPINS-1:0] drive_q;
    logic [NPINS-1:0] drive_next;
    logic             hdr_act;
    logic [NPINS-1:0] snap;
    logic             alarm_any;

    assign alarm_any = alarm_hi | alarm_lo;
    assign pd_active = cfg_q.pd_en & ~pin_in[PD_PIN];

    gpio_fs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .pd_req  (pd_active),
        .cs_fall (cs_fall),
        .pd_flag (pd_flag)
    );

    gpio_fs_cfg #(.NARROW(NARROW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word_in    (word_in),
        .cs_fall    (cs_fall),
        .cfg_q      (cfg_q),
        .drive_q    (drive_q),
        .drive_next (drive_next),
        .hdr_act    (hdr_act)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_fs_pin #(
            .HAS_ALARM (i == ALM_PIN),
            .HAS_PD    (i == PD_PIN)
        ) u_pin (
            .clk        (clk),
            .rst        (rst),
            .cs_fall    (cs_fall),
            .dir        (cfg_q.dir[i]),
            .func_en    ((i == ALM_PIN) ? cfg_q.alarm_en : cfg_q.pd_en),
            .alarm_any  (alarm_any),
            .drive_q    (drive_q[i]),
            .drive_next (drive_next[i]),
            .pad_in     (pin_in[i]),
            .pad_out    (pin_out[i]),
            .pad_oe     (pin_oe[i]),
            .snap       (snap[i])
        );
    end

    assign sdo_word = {(hdr_act ? snap : chan_tag), result};
endmodule

// File: rtl/gpio_fs_chk.sv
module gpio_fs_chk #(
    parameter bit NARROW = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       word_valid,
    input logic [3:0] w_op,
    input logic [5:0] w_rsv,
    input logic       w_pd,
    input logic [2:0] w_dhi,
    input logic [3:0] pin_oe,
    input logic [2:0] pin_out_hi,
    input logic       pd_active,
    input logic       pd_flag,
    input logic       alarm_en,
    input logic       pd_en,
    input logic       hdr_act,
    input logic [3:0] snap
);
    logic cs_d;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) cs_d <= 1'b1;
        else     cs_d <= cs_n;
    end
    assign fall = cs_d & ~cs_n;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (pin_oe == 4'b0 && !pd_flag && !hdr_act));

    a_r3_drive_holds: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(pin_out_hi));

    a_r4_snap_holds: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(snap));

    a_r5_header_holds: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(hdr_act));

    a_r6_alarm_driven: assert property (@(posedge clk) disable iff (rst)
        alarm_en |-> pin_oe[0]);

    a_r7_pd_undriven: assert property (@(posedge clk) disable iff (rst)
        pd_en |-> !pin_oe[3]);

    a_r7_flag_late: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_flag) |-> $past(pd_active, 2));

    a_r8_narrow_reject: assert property (@(posedge clk) disable iff (rst)
        (NARROW && word_valid && w_op == 4'h4 && (w_dhi != 3'b111 || w_pd))
        |=> $stable(pin_oe));

    a_r9_ignored_word: assert property (@(posedge clk) disable iff (rst)
        (word_valid && ((w_op != 4'h1 && w_op != 4'h4) || (w_op == 4'h4 && w_rsv != 6'b0)))
        |=> $stable(pin_oe));
endmodule

bind gpio_fs_ctrl gpio_fs_chk #(.NARROW(NARROW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .word_valid (word_valid),
    .w_op       (word_in[15:12]),
    .w_rsv      ({word_in[11:10], word_in[7:4]}),
    .w_pd       (word_in[9]),
    .w_dhi      (word_in[3:1]),
    .pin_oe     (pin_oe),
    .pin_out_hi (pin_out[3:1]),
    .pd_active  (pd_active),
    .pd_flag    (pd_flag),
    .alarm_en   (cfg_q.alarm_en),
    .pd_en      (cfg_q.pd_en),
    .hdr_act    (hdr_act),
    .snap       (snap)
);

// File: tb/tb_gpio_fs_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_fs_ctrl;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        word_valid = 1'b0;
    logic [15:0] word_in = '0;
    logic [3:0]  chan_tag = 4'h9;
    logic [11:0] result = 12'hA5C;
    logic        alarm_hi = 1'b0;
    logic        alarm_lo = 1'b0;
    logic [3:0]  pin_in = '0;

    logic [3:0]  pin_out, pin_oe, n_pin_out, n_pin_oe;
    logic [15:0] sdo_word, n_sdo_word;
    logic        pd_active, pd_flag, n_pd_active, n_pd_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_fs_ctrl dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .word_valid(word_valid), .word_in(word_in),
        .chan_tag(chan_tag), .result(result), .alarm_hi(alarm_hi), .alarm_lo(alarm_lo),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .sdo_word(sdo_word),
        .pd_active(pd_active), .pd_flag(pd_flag)
    );

    gpio_fs_ctrl #(.NARROW(1'b1)) dut_nar (
        .clk(clk), .rst(rst), .cs_n(cs_n), .word_valid(word_valid), .word_in(word_in),
        .chan_tag(chan_tag), .result(result), .alarm_hi(alarm_hi), .alarm_lo(alarm_lo),
        .pin_in(pin_in), .pin_out(n_pin_out), .pin_oe(n_pin_oe), .sdo_word(n_sdo_word),
        .pd_active(n_pd_active), .pd_flag(n_pd_flag)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        word_valid = 1'b1;
        word_in    = w;
        step();
        word_valid = 1'b0;
        word_in    = '0;
        step();
    endtask

    task automatic frame_start();
        cs_n = 1'b1;
        step();
        step();
        cs_n = 1'b0;
        step();
    endtask

    initial begin
        #(MAX_CYCLES * 5.0);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [3:0] prev;
        step();
        step();
        step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 oe", {12'b0, pin_oe}, 16'h0);
        chk("R1 out", {12'b0, pin_out}, 16'h0);
        chk("R1 header", sdo_word, {chan_tag, result});
        chk("R1 pd_flag", {15'b0, pd_flag}, 16'h0);

        // R2 direction sweep
        for (int d = 0; d < 16; d++) begin
            send_word(16'h4000 | 16'(d));
            chk("R2 direction", {12'b0, pin_oe}, 16'(d));
        end

        // R3 output pipeline sweep
        send_word(16'h400F);
        prev = pin_out;
        for (int v = 0; v < 16; v++) begin
            send_word(16'h1000 | 16'(v));
            chk("R3 hold before edge", {12'b0, pin_out}, {12'b0, prev});
            frame_start();
            chk("R3 driven at edge", {12'b0, pin_out}, 16'(v));
            prev = 4'(v);
        end

        // R5 header off carries channel tag; select is pipelined
        send_word(16'h1010);
        chk("R5 header select waits", sdo_word, {chan_tag, result});

        // R4 R5 R10 direction x pin pattern sweep
        for (int d = 0; d < 16; d++) begin
            for (int p = 0; p < 16; p++) begin
                logic [3:0] v;
                logic [3:0] dd;
                logic [3:0] pp;
                dd = 4'(d);
                pp = 4'(p);
                v  = pp ^ 4'hA;
                send_word(16'h4000 | 16'(d));
                send_word(16'h1010 | {12'b0, v});
                pin_in = pp;
                frame_start();
                pin_in = ~pp;
                step();
                chk("R4 R5 R10 header snapshot", sdo_word, {(v & dd) | (pp & ~dd), result});
            end
        end

        send_word(16'h1000);
        frame_start();
        chk("R5 header back to tag", sdo_word, {chan_tag, result});

        // R6 alarm role on pin 0
        send_word(16'h4100);
        chk("R6 pin0 driven", {12'b0, pin_oe}, 16'h1);
        alarm_hi = 1'b1; #1;
        chk("R6 alarm hi", {15'b0, pin_out[0]}, 16'h1);
        alarm_hi = 1'b0; #1;
        chk("R6 alarm clear", {15'b0, pin_out[0]}, 16'h0);
        alarm_lo = 1'b1; #1;
        chk("R6 alarm lo", {15'b0, pin_out[0]}, 16'h1);
        step();
        send_word(16'h1010);
        pin_in = 4'h0;
        frame_start();
        chk("R6 alarm in header", {12'b0, sdo_word[15:12]}, 16'h1);
        alarm_lo = 1'b0;

        // R7 power-down role on pin 3
        pin_in = 4'hF;
        send_word(16'h400F);
        chk("R7 no role no request", {15'b0, pd_active}, 16'h0);
        send_word(16'h420F);
        chk("R7 pin3 undriven", {12'b0, pin_oe}, 16'h7);
        chk("R7 idle request", {15'b0, pd_active}, 16'h0);
        pin_in = 4'h7; #1;
        chk("R7 request immediate", {15'b0, pd_active}, 16'h1);
        step();
        chk("R7 flag not yet", {15'b0, pd_flag}, 16'h0);
        step();
        chk("R7 flag after two clocks", {15'b0, pd_flag}, 16'h1);
        pin_in = 4'hF;
        step();
        step();
        step();
        chk("R7 flag clears", {15'b0, pd_flag}, 16'h0);

        // R8 narrow variant
        send_word(16'h400E);
        chk("R8 narrow legal", {12'b0, n_pin_oe}, 16'hE);
        send_word(16'h4003);
        chk("R8 narrow rejects input pins", {12'b0, n_pin_oe}, 16'hE);
        chk("R2 wide accepts", {12'b0, pin_oe}, 16'h3);
        send_word(16'h420E);
        chk("R8 narrow rejects power-down", {12'b0, n_pin_oe}, 16'hE);
        send_word(16'h410F);
        chk("R8 narrow alarm legal", {12'b0, n_pin_oe}, 16'hF);

        // R9 ignored words
        send_word(16'h4005);
        send_word(16'h4805);
        chk("R9 reserved bit 11", {12'b0, pin_oe}, 16'h5);
        send_word(16'h4025);
        chk("R9 reserved bit 5", {12'b0, pin_oe}, 16'h5);
        send_word(16'h1003);
        frame_start();
        chk("R9 setup", {12'b0, pin_out}, 16'h3);
        send_word(16'h200C);
        send_word(16'h000C);
        send_word(16'h701C);
        frame_start();
        chk("R9 other opcodes keep outputs", {12'b0, pin_out}, 16'h3);
        chk("R9 other opcodes keep header", sdo_word, {chan_tag, result});
        chk("R9 other opcodes keep dirs", {12'b0, pin_oe}, 16'h5);

        report();
    end
endmodule